// File: doc/BRIEF.md
# Window Centering Strobe Sequencer

This block automatically centers the detection window of a data synchronizer. It does so by sweeping the synchronizer's signed strobe setting. When it is started, it moves the strobe away from nominal in the early (negative) direction, one step at a time. At each setting it performs a test read: it raises the read gate and waits for an external error measurement. It keeps stepping until the reported error count exceeds a threshold set above the nominal error rate. It records that setting, then repeats the search in the late (positive) direction.

The two crossing points bound the usable window. Their mean, truncated toward zero, is programmed as the final strobe word. The strobe word only ever changes while the read gate is low. Every change is followed by a programmable settling wait before the next read gate, or before completion is reported.

Measuring errors and moving the word over the serial bus to the synchronizer are outside this block. The block presents the word together with a one-cycle load request.

Top module: `strobe_centering_seq`

## Requirements
- R1: After reset, strobe_word is 0, and read_gate, strobe_load, done, early_at_limit and late_at_limit are all 0.
- R2: After start, the early sweep presents strobe words -1, -2, -3, and so on, one per test read. strobe_word is 5-bit two's complement, and a negative value means an early shift.
- R3: strobe_word changes only in a cycle where read_gate is low both before and after the change. Each new word is accompanied by a one-cycle strobe_load pulse in the first cycle it is visible.
- R4: read_gate rises, or done rises for the final word, exactly settle_cycles+1 cycles after the strobe_load pulse. settle_cycles is sampled when start is seen.
- R5: read_gate stays high until err_valid arrives, and falls the cycle after. A read counts as a crossing only when err_count is strictly greater than err_threshold, which is sampled at start. err_valid while read_gate is low has no effect.
- R6: At the first early crossing, that word is stored and the late sweep begins at +1, then presents +2, +3, and so on.
- R7: If a direction reaches its limit magnitude without a crossing, the limit value is recorded for that direction and the matching flag is set: early_at_limit for the early sweep, late_at_limit for the late sweep.
- R8: The limit magnitude is 6 when narrow_range is 1 at start, and 15 otherwise. No presented word exceeds the limit.
- R9: The final word is (early + late) / 2 truncated toward zero. It is loaded with a strobe_load pulse, and after the settling wait done is held high with read_gate low.
- R10: start restarts the routine from any state. The next cycle has read_gate, done and both flags low, and the sweep begins again at -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart the centering routine |
| narrow_range | input | 1 | Restrict the sweep to magnitude 6 |
| settle_cycles | input | 24 | Settling wait after each strobe change |
| err_threshold | input | 16 | Error count that must be exceeded |
| err_valid | input | 1 | One-cycle pulse: err_count holds a test-read result |
| err_count | input | 16 | Error count of the current test read |
| strobe_word | output | 5 | Signed strobe setting for the synchronizer |
| strobe_load | output | 1 | One-cycle request to transfer strobe_word |
| read_gate | output | 1 | High during a test read |
| done | output | 1 | Centered value programmed and settled |
| early_at_limit | output | 1 | Early sweep ended at its limit with no crossing |
| late_at_limit | output | 1 | Late sweep ended at its limit with no crossing |

## Verification
The sweep is driven by a bench model of the window: an early and a late crossing magnitude, with counts above the threshold outside that window and counts at or below it inside. Directed windows separate truncation toward zero from flooring (crossings -2/+1 and -1/+2 both give 0), and show when each limit flag is set in wide and narrow mode. Random windows, thresholds including zero, and settling times from 0 to 40 check the word sequence and the exact settle spacing. A spurious err_valid during settling, and changes to the sampled inputs after start, tell a design that samples correctly from one that does not; an abort during a read checks the restart.

// File: rtl/strobe_centering_seq.sv
module strobe_centering_seq #(
  parameter int MAX_MAG    = 15,
  parameter int NARROW_MAG = 6,
  parameter int CNT_W      = 16,
  parameter int SETTLE_W   = 24,
  localparam int SW        = $clog2(MAX_MAG + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 narrow_range,
  input  logic [SETTLE_W-1:0]  settle_cycles,
  input  logic [CNT_W-1:0]     err_threshold,
  input  logic                 err_valid,
  input  logic [CNT_W-1:0]     err_count,
  output logic signed [SW-1:0] strobe_word,
  output logic                 strobe_load,
  output logic                 read_gate,
  output logic                 done,
  output logic                 early_at_limit,
  output logic                 late_at_limit
);

  localparam logic signed [SW-1:0] WIDE_LIM = SW'(MAX_MAG);
  localparam logic signed [SW-1:0] NARR_LIM = SW'(NARROW_MAG);

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_SETTLE, ST_READ, ST_DONE} state_t;
  typedef enum logic [1:0] {PH_EARLY, PH_LATE, PH_FINAL} phase_t;

  state_t                state;
  phase_t                phase;
  logic signed [SW-1:0]  cand, early_set, lim_q;
  logic [SETTLE_W-1:0]   settle_q, wait_cnt;
  logic [CNT_W-1:0]      thresh_q;
  logic                  over;
  logic signed [SW:0]    pair_sum, half;

  assign read_gate = (state == ST_READ);
  assign done      = (state == ST_DONE);
  assign over      = err_count > thresh_q;
  assign pair_sum  = {early_set[SW-1], early_set} + {cand[SW-1], cand};
  assign half      = $signed(pair_sum + {{SW{1'b0}}, pair_sum[SW]}) >>> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      phase          <= PH_EARLY;
      cand           <= '0;
      early_set      <= '0;
      lim_q          <= WIDE_LIM;
      settle_q       <= '0;
      wait_cnt       <= '0;
      thresh_q       <= '0;
      strobe_word    <= '0;
      strobe_load    <= 1'b0;
      early_at_limit <= 1'b0;
      late_at_limit  <= 1'b0;
    end else begin
      strobe_load <= 1'b0;
      if (start) begin
        state          <= ST_LOAD;
        phase          <= PH_EARLY;
        cand           <= '1;
        early_at_limit <= 1'b0;
        late_at_limit  <= 1'b0;
        settle_q       <= settle_cycles;
        thresh_q       <= err_threshold;
        lim_q          <= narrow_range ? NARR_LIM : WIDE_LIM;
      end else begin
        case (state)
          ST_LOAD: begin
            strobe_word <= cand;
            strobe_load <= 1'b1;
            wait_cnt    <= settle_q;
            state       <= ST_SETTLE;
          end
          ST_SETTLE: begin
            if (wait_cnt == '0)
              state <= (phase == PH_FINAL) ? ST_DONE : ST_READ;
            else
              wait_cnt <= wait_cnt - 1'b1;
          end
          ST_READ: begin
            if (err_valid) begin
              state <= ST_LOAD;
              if (phase == PH_EARLY) begin
                if (over || cand == -lim_q) begin
                  early_set      <= cand;
                  early_at_limit <= !over;
                  phase          <= PH_LATE;
                  cand           <= SW'(1);
                end else begin
                  cand <= cand - 1'b1;
                end
              end else begin
                if (over || cand == lim_q) begin
                  late_at_limit <= !over;
                  phase         <= PH_FINAL;
                  cand          <= half[SW-1:0];
                end else begin
                  cand <= cand + 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [SETTLE_W:0] since_load;
  always_ff @(posedge clk) begin
    if (!rst_n)
      since_load <= '0;
    else if (strobe_load)
      since_load <= {{SETTLE_W{1'b0}}, 1'b1};
    else if (since_load != '1)
      since_load <= since_load + 1'b1;
  end

  AST_STROBE_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_word != $past(strobe_word)) |-> (!read_gate && !$past(read_gate))); // R3

  AST_LOAD_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_load |-> (!read_gate && !done)); // R3

  AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_gate) |-> (since_load > {1'b0, settle_q})); // R4

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (read_gate && !err_valid && !start) |=> read_gate); // R5

  AST_WORD_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_load |-> (strobe_word <= lim_q && strobe_word >= -lim_q)); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!read_gate && !strobe_load)); // R9

endmodule

// File: tb/sim_strobe_centering_seq.sv
`timescale 1ns/1ps
module sim_strobe_centering_seq;
  localparam int CNT_W = 16;
  localparam int SETTLE_W = 24;
  localparam int SW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, narrow_range = 1'b0, err_valid = 1'b0;
  logic [SETTLE_W-1:0] settle_cycles = '0;
  logic [CNT_W-1:0] err_threshold = '0, err_count = '0;
  logic signed [SW-1:0] strobe_word;
  logic strobe_load, read_gate, done, early_at_limit, late_at_limit;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  strobe_centering_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .narrow_range(narrow_range),
    .settle_cycles(settle_cycles), .err_threshold(err_threshold),
    .err_valid(err_valid), .err_count(err_count),
    .strobe_word(strobe_word), .strobe_load(strobe_load), .read_gate(read_gate),
    .done(done), .early_at_limit(early_at_limit), .late_at_limit(late_at_limit));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      check(1'b0, "watchdog", "cycles", cycles, 0);
      report();
      $finish;
    end
  end

  task automatic run_case(input int e_mag, input int l_mag, input bit narrow,
                          input int settle, input int thr, input bit spurious);
    int lim, ph, m, e_set, l_set, k, w, d, sw;
    bit e_l, l_l, fin, fail;
    string rq;
    lim = narrow ? 6 : 15;
    ph = 0; m = -1; e_set = 0; l_set = 0; e_l = 0; l_l = 0; fin = 0;
    @(negedge clk);
    narrow_range = narrow; settle_cycles = SETTLE_W'(settle); err_threshold = CNT_W'(thr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!read_gate && !done, "R10", "gate/done after start", {read_gate, done}, 0);
    check(!early_at_limit && !late_at_limit, "R10", "flags after start", {early_at_limit, late_at_limit}, 0);
    settle_cycles = SETTLE_W'(settle + 3);
    err_threshold = CNT_W'(thr + 50);
    narrow_range = !narrow;
    while (1) begin
      w = 0;
      while (!strobe_load && w < 5000) begin @(negedge clk); w++; end
      rq = (ph == 0) ? "R2" : (ph == 1) ? "R6" : "R9";
      sw = strobe_word;
      check(strobe_load == 1'b1, "R3", "load pulse seen", strobe_load, 1);
      check(sw == m, rq, "strobe word", sw, m);
      check(sw <= lim && sw >= -lim, "R8", "word within limit", sw, lim);
      k = 0;
      do begin
        @(negedge clk); k++;
        if (spurious && settle >= 1 && k == 1) begin
          check(!read_gate, "R5", "gate low for spurious", read_gate, 0);
          err_valid = 1'b1; err_count = CNT_W'(thr + 100);
        end else begin
          err_valid = 1'b0;
        end
      end while (!read_gate && !done && k < 100000);
      err_valid = 1'b0;
      if (fin) begin
        check(done && !read_gate, "R9", "done with gate low", {done, read_gate}, 2);
        check(k == settle + 1, "R4", "settle before done", k, settle + 1);
        check(early_at_limit == e_l, "R7", "early limit flag", early_at_limit, e_l);
        check(late_at_limit == l_l, "R7", "late limit flag", late_at_limit, l_l);
        break;
      end
      check(read_gate && !done, "R5", "read gate up", read_gate, 1);
      check(k == settle + 1, "R4", "settle before read", k, settle + 1);
      d = $urandom_range(0, 3);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        check(read_gate == 1'b1, "R5", "gate held awaiting result", read_gate, 1);
      end
      fail = (ph == 0) ? (m <= -e_mag) : (m >= l_mag);
      if (fail) err_count = CNT_W'(thr + 1 + $urandom_range(0, 4));
      else if ($urandom_range(0, 2) == 0) err_count = CNT_W'(thr);
      else err_count = CNT_W'($urandom_range(0, thr));
      err_valid = 1'b1;
      @(negedge clk);
      err_valid = 1'b0;
      check(read_gate == 1'b0, "R5", "gate drop after result", read_gate, 0);
      if (ph == 0) begin
        if (fail || m == -lim) begin e_set = m; e_l = !fail; ph = 1; m = 1; end
        else m--;
      end else begin
        if (fail || m == lim) begin l_set = m; l_l = !fail; ph = 2; m = (e_set + l_set) / 2; fin = 1; end
        else m++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    begin
      int sw0;
      sw0 = strobe_word;
      check(sw0 == 0, "R1", "reset strobe word", sw0, 0);
      check(!read_gate && !strobe_load && !done, "R1", "reset controls", {read_gate, strobe_load, done}, 0);
      check(!early_at_limit && !late_at_limit, "R1", "reset flags", {early_at_limit, late_at_limit}, 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!read_gate && !done, "R1", "idle after reset", {read_gate, done}, 0);

    run_case(3, 5, 0, 2, 10, 1);
    run_case(4, 4, 0, 1, 7, 0);
    run_case(1, 2, 0, 0, 3, 0);
    run_case(2, 1, 0, 3, 5, 1);
    run_case(20, 20, 0, 1, 4, 0);
    run_case(9, 3, 1, 2, 6, 1);
    run_case(16, 1, 0, 0, 0, 0);
    run_case(2, 9, 1, 40, 12, 1);
    run_case(7, 8, 0, 2, 0, 1);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int w;
      w = 0;
      while (!read_gate && w < 1000) begin @(negedge clk); w++; end
    end
    run_case(5, 6, 1, 1, 9, 0);

    for (int n = 0; n < 14; n++) begin
      run_case($urandom_range(1, 17), $urandom_range(1, 17), $urandom_range(0, 1),
               $urandom_range(0, 5), $urandom_range(0, 30), $urandom_range(0, 1));
    end

    report();
    $finish;
  end
endmodule